// File: doc/BRIEF.md
# Per-Bit Shared-Logic Carry Select Adder

This block adds two N-bit unsigned operands and a one-bit carry input and returns an N-bit sum with a carry output. It is purely combinational: there is no clock, no reset and no state. The outputs follow the inputs within one settling delay.

Every bit position is its own small select block. From its two operand bits, a bit works out two outcomes before its incoming carry is known: one for a carry of 0 and one for a carry of 1. Both outcomes come from one shared set of gates rather than two copies of a full adder.

- The sum candidate for carry 0 is the XOR of the operand bits. The sum candidate for carry 1 is that XOR inverted.
- The carry candidate for carry 0 is the AND of the operand bits. The carry candidate for carry 1 is their OR.

A two-way multiplexer at each bit then takes the carry picked at the bit below and uses it to choose the real sum bit and the real outgoing carry. The external carry input drives the choice at bit 0. The carry chosen at the top bit is the carry output. The chain passes through one multiplexer per bit, so the worst-case delay still grows linearly with N.

Top module: `csel_adder`

## Requirements
- R1: For every input combination, the concatenation {cout, sum} equals a + b + cin taken as an unsigned (N+1)-bit value.
- R2: When the carry entering a bit is 0, that sum bit equals a XOR b at that position; when the carry is 1, it equals the inverse of a XOR b. At bit 0 the entering carry is cin.
- R3: The carry leaving a bit equals a AND b at that position when the entering carry is 0, and a OR b when it is 1. Therefore cout is 1 whenever both top operand bits are 1, and 0 whenever both are 0.
- R4: The external carry input selects the outcome of bit 0, and the carry selected at bit N-1 is driven on cout.
- R5: An all-ones operand plus zero plus a carry input of 1 gives sum zero and cout 1, with the carry travelling through every bit.
- R6: Zero plus zero with carry input 0 gives sum zero and cout 0.
- R7: The alternating patterns 0x5555_5555 and 0xAAAA_AAAA, each added to itself and to the other, with either carry input, give the arithmetic result (32-bit default).
- R8: The width parameter N (default 32, minimum 1) sets the operand and sum widths exactly. The adder is correct at N = 1, N = 4 and N = 32.
- R9: The outputs depend only on the present inputs. A new input vector is reflected on the outputs within the same clock period of the surrounding logic, with no register delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | First operand, unsigned |
| b | input | N | Second operand, unsigned |
| cin | input | 1 | Carry into bit 0 |
| sum | output | N | Low N bits of a + b + cin |
| cout | output | 1 | Carry out of bit N-1 |

## Verification
Two functions can land on the same input vector: the choice at bit 0 made by the carry input, and the full-length carry travel through every per-bit multiplexer. All-ones plus zero with a carry input of 1 triggers both at once. Alternating patterns with a carry input of 1 flip the multiplexer choice at every position. Each vector is judged against a wide integer sum formed in the bench, once the inputs have settled and well away from the clock edge. The same comparison runs exhaustively on 4-bit and 1-bit copies, where every pairing of candidates and entering carries appears.

// File: rtl/csel_pkg.sv
// Package: shared types for the per-bit carry select adder.
// Assumes: nothing beyond IEEE 1800-2017 packed structs.
package csel_pkg;

    // Both outcomes prepared by one bit before its incoming carry is known.
    typedef struct packed {
        logic sum_if0;    // sum bit when the entering carry is 0
        logic sum_if1;    // sum bit when the entering carry is 1
        logic carry_if0;  // outgoing carry when the entering carry is 0
        logic carry_if1;  // outgoing carry when the entering carry is 1
    } bit_cand_t;

endpackage

// File: rtl/csel_cand.sv
// Module: csel_cand
// Builds both candidate outcomes for one bit from shared gates: a single
// XOR feeds both sum candidates (direct and inverted), and one AND plus
// one OR give the two carry candidates.
// Assumes: one bit of each operand; purely combinational.
module csel_cand
    import csel_pkg::*;
(
    input  logic      op_a,
    input  logic      op_b,
    output bit_cand_t cand
);

    logic diff;

    // Form the shared difference term and derive all four candidates from it.
    always_comb begin
        diff           = op_a ^ op_b;
        cand.sum_if0   = diff;
        cand.sum_if1   = ~diff;
        cand.carry_if0 = op_a & op_b;
        cand.carry_if1 = op_a | op_b;
    end

endmodule

// File: rtl/csel_pick.sv
// Module: csel_pick
// Two-way selector for one bit: the carry chosen at the bit below picks
// the real sum bit and the real outgoing carry from the candidates.
// Assumes: sel_carry has settled from the lower bit; purely combinational.
module csel_pick
    import csel_pkg::*;
(
    input  bit_cand_t cand,
    input  logic      sel_carry,
    output logic      sum_bit,
    output logic      carry_out
);

    // Steer the candidate pair that matches the entering carry.
    always_comb begin
        if (sel_carry) begin
            sum_bit   = cand.sum_if1;
            carry_out = cand.carry_if1;
        end else begin
            sum_bit   = cand.sum_if0;
            carry_out = cand.carry_if0;
        end
    end

endmodule

// File: rtl/csel_adder.sv
// Module: csel_adder (top)
// N-bit unsigned adder made of N independent select blocks. Each bit
// prepares both outcomes with shared gates, and a per-bit selector chained
// on the carry picks the real one. cin drives the selector of bit 0, and
// the carry selected at bit N-1 leaves as cout.
// Assumes: N >= 1. No clock or reset: the block is combinational.
module csel_adder #(
    parameter int N = 32
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         cin,
    output logic [N-1:0] sum,
    output logic         cout
);
    import csel_pkg::*;

    localparam int CHAIN_W = N + 1;

    logic [CHAIN_W-1:0] chain;
    bit_cand_t          cands [N];

    // Feed the external carry into the bottom of the selection chain.
    assign chain[0] = cin;

    // One select block per bit: candidate logic followed by its selector.
    for (genvar i = 0; i < N; i++) begin : g_bit
        csel_cand u_cand (
            .op_a (a[i]),
            .op_b (b[i]),
            .cand (cands[i])
        );

        csel_pick u_pick (
            .cand      (cands[i]),
            .sel_carry (chain[i]),
            .sum_bit   (sum[i]),
            .carry_out (chain[i+1])
        );
    end

    // Carry selected at the top bit leaves the block.
    assign cout = chain[N];

endmodule

// File: rtl/csel_adder_chk.sv
// Module: csel_adder_chk
// Assertion checker bound to csel_adder. The block is combinational, so
// the checks are immediate assertions that run whenever a port changes.
// Assumes: N >= 1.
module csel_adder_chk #(
    parameter int N = 32
) (
    input logic [N-1:0] a,
    input logic [N-1:0] b,
    input logic         cin,
    input logic [N-1:0] sum,
    input logic         cout
);

    logic [N:0] wide_ref;

    // Check the port relations after every change of any port.
    always_comb begin
        wide_ref = {1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin};

        // R1: full arithmetic result
        assert_sum_matches_R1: assert ({cout, sum} == wide_ref)
            else $error("R1 violated: a=%h b=%h cin=%b", a, b, cin);

        // R2: bit 0 sum candidate chosen by cin
        assert_bit0_sum_R2: assert (sum[0] == (cin ? ~(a[0] ^ b[0]) : (a[0] ^ b[0])))
            else $error("R2 violated at bit 0");

        // R3: top-bit generate forces carry out, top-bit kill blocks it
        assert_top_carry_R3: assert (!(a[N-1] && b[N-1]) || cout)
            else $error("R3 violated: generate without cout");
        assert_top_kill_R3: assert ((a[N-1] || b[N-1]) || !cout)
            else $error("R3 violated: kill with cout");

        // R5: all ones plus zero plus carry travels through every bit
        assert_full_travel_R5: assert (!((&a) && (b == '0) && cin) || (cout && (sum == '0)))
            else $error("R5 violated");
    end

endmodule

bind csel_adder csel_adder_chk #(.N(N)) u_chk (
    .a    (a),
    .b    (b),
    .cin  (cin),
    .sum  (sum),
    .cout (cout)
);

// File: tb/sim_csel_adder.sv
module sim_csel_adder;

    logic clk = 1'b0;
    always #5 clk = ~clk;   // 100 MHz

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // 32-bit device under test
    logic [31:0] a0, b0, s0;
    logic        c0, co0;
    csel_adder #(.N(32)) u0 (.a(a0), .b(b0), .cin(c0), .sum(s0), .cout(co0));

    // 4-bit copy for exhaustive coverage
    logic [3:0] a1, b1, s1;
    logic       c1, co1;
    csel_adder #(.N(4)) u1 (.a(a1), .b(b1), .cin(c1), .sum(s1), .cout(co1));

    // 1-bit copy: one select block on its own
    logic a2, b2, s2, c2, co2;
    csel_adder #(.N(1)) u2 (.a(a2), .b(b2), .cin(c2), .sum(s2), .cout(co2));

    // Apply a 32-bit vector after the edge, sample mid-period.
    task automatic try32(input logic [31:0] xa, input logic [31:0] xb,
                         input logic xc, input string req);
        longint unsigned expv;
        logic [32:0] got;
        @(posedge clk);
        #1;
        a0 = xa; b0 = xb; c0 = xc;
        expv = longint'(xa) + longint'(xb) + longint'(xc);
        #3;
        got = {co0, s0};
        checks++;
        if (got != expv[32:0]) begin
            fails++;
            $display("FAIL %s: a=%h b=%h cin=%b got=%h exp=%h",
                     req, xa, xb, xc, got, expv[32:0]);
        end
    endtask

    initial begin
        a0 = '0; b0 = '0; c0 = 1'b0;
        a1 = '0; b1 = '0; c1 = 1'b0;
        a2 = 1'b0; b2 = 1'b0; c2 = 1'b0;

        // R6: zero plus zero
        try32(32'h0, 32'h0, 1'b0, "R6");
        // R5: all ones plus zero with carry in, full travel
        try32(32'hFFFF_FFFF, 32'h0, 1'b1, "R5");
        // R5: all ones plus all ones plus carry
        try32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R5");
        // R7: alternating patterns, both carries
        for (int k = 0; k < 2; k++) begin
            try32(32'h5555_5555, 32'hAAAA_AAAA, k[0], "R7");
            try32(32'h5555_5555, 32'h5555_5555, k[0], "R7");
            try32(32'hAAAA_AAAA, 32'hAAAA_AAAA, k[0], "R7");
        end
        // R4: carry input alone reaches bit 0 and cout from the top bit
        try32(32'h0, 32'h0, 1'b1, "R4");
        try32(32'h8000_0000, 32'h8000_0000, 1'b0, "R4");
        // R9: back-to-back vectors each settle within one period
        try32(32'h1234_5678, 32'h8765_4321, 1'b0, "R9");
        try32(32'hFFFF_0000, 32'h0001_0000, 1'b1, "R9");
        // R1: random vectors
        for (int k = 0; k < 400; k++)
            try32($urandom, $urandom, $urandom_range(0, 1), "R1");

        // R8/R1: exhaustive at N=4
        for (int x = 0; x < 16; x++)
            for (int y = 0; y < 16; y++)
                for (int z = 0; z < 2; z++) begin
                    @(posedge clk);
                    #1;
                    a1 = x[3:0]; b1 = y[3:0]; c1 = z[0];
                    #3;
                    checks++;
                    if ({co1, s1} != 5'(x + y + z)) begin
                        fails++;
                        $display("FAIL R8 (N=4): a=%0d b=%0d cin=%0d got=%0d exp=%0d",
                                 x, y, z, {co1, s1}, x + y + z);
                    end
                end

        // R2/R3/R8: single bit, candidate choice for every entering carry
        for (int x = 0; x < 2; x++)
            for (int y = 0; y < 2; y++)
                for (int z = 0; z < 2; z++) begin
                    @(posedge clk);
                    #1;
                    a2 = x[0]; b2 = y[0]; c2 = z[0];
                    #3;
                    checks++;
                    if (s2 != ((x + y + z) % 2 == 1)) begin
                        fails++;
                        $display("FAIL R2: a=%0d b=%0d cin=%0d got=%b exp=%0d",
                                 x, y, z, s2, (x + y + z) % 2);
                    end
                    checks++;
                    if (co2 != ((x + y + z) >= 2)) begin
                        fails++;
                        $display("FAIL R3: a=%0d b=%0d cin=%0d got=%b exp=%0d",
                                 x, y, z, co2, (x + y + z) >= 2);
                    end
                end

        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog: got=timeout exp=done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule